// File: doc/BRIEF.md
# Cipher Operand Bypass Unit

This block sits beside the decode stage of a pipelined processor that carries a two-round block-cipher functional unit. The cipher unit reads a 64-bit data block and a 128-bit key from a small extended register file. Instructions that write those registers may still be in flight when a cipher instruction needs them. This unit looks at the writes travelling through the execute, memory and write-back stages and hands the cipher unit the values those registers are about to hold. The block goes to the ID/EX register and the four key words go to round-key generation.

Two instruction kinds can write an extended register with an XOR result. These are an XOR of two integer registers and an XOR of an integer register with an extended register. Both carry a 4-bit extended destination address. A cipher instruction produces a whole new 64-bit block. The unit forwards that block from its final step while it is still in execute, and keeps forwarding it while it waits in memory and write-back. Any other instruction kind is ignored. For every stage the unit also raises a flag telling the integer forwarding logic that the stage's destination is an extended register, so the integer pipeline does not see a false hazard.

The unit is purely combinational. Each output follows its inputs within the same cycle.

Top module: `cipher_operand_bypass`

## Requirements
- R1: When no stage carries an extended-register instruction, `cur_block` equals `rf_block` and `cur_key` equals `rf_key`.
- R2: A stage whose kind is 1 (integer XOR integer) or 2 (integer XOR extended) with address 0..5 replaces that register's word with bits [31:0] of its data. Address 0 is `cur_block[63:32]`, address 1 is `cur_block[31:0]`, and address 2+k is `cur_key[127-32k -: 32]`.
- R3: A stage whose kind is 0 changes no output, whatever its address and data.
- R4: An XOR write to address 6 or higher (the constant registers) is not forwarded.
- R5: When several stages hit the same register, execute beats memory, memory beats write-back, and write-back beats the register file. The choice is made separately for each register.
- R6: A stage in execute with kind 3 (cipher) replaces the whole block with its 64-bit data only while `ex_last_step` is 1. The key words are never affected by a cipher result.
- R7: A kind 3 stage in memory or write-back replaces the whole block with its data, whatever the value of `ex_last_step`.
- R8: A cipher result and an XOR write to register 0 or 1 are ordered by age. A younger XOR in execute beats a cipher result in memory. A cipher result at its last step beats an older XOR in memory or write-back.
- R9: `int_bypass_kill[s]` is 1 exactly when stage s (bit 0 execute, bit 1 memory, bit 2 write-back) has a nonzero kind.
- R10: All outputs depend only on the current inputs, with zero cycles of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_kind | input | 2 | Execute-stage instruction kind: 0 other, 1 int-XOR-int, 2 int-XOR-ext, 3 cipher |
| ex_addr | input | 4 | Execute-stage extended destination address |
| ex_data | input | 64 | Execute-stage result; XOR kinds use [31:0] |
| ex_last_step | input | 1 | Cipher instruction is in its final step |
| mem_kind | input | 2 | Memory-stage instruction kind |
| mem_addr | input | 4 | Memory-stage extended destination address |
| mem_data | input | 64 | Memory-stage result |
| wb_kind | input | 2 | Write-back-stage instruction kind |
| wb_addr | input | 4 | Write-back-stage extended destination address |
| wb_data | input | 64 | Write-back-stage result |
| rf_block | input | 64 | Stored block, registers 0 (high) and 1 (low) |
| rf_key | input | 128 | Stored key, register 2 in the top word down to register 5 |
| cur_block | output | 64 | Up-to-date block for the ID/EX register |
| cur_key | output | 128 | Up-to-date key words for round-key generation |
| int_bypass_kill | output | 3 | Per stage, suppress integer forwarding |

## Verification
Every result of this unit is due in the same cycle as the stimulus that causes it, because no register lies between its inputs and outputs. The driver applies each input pattern just after a rising edge and places the expected values in a queue. The monitor pops and compares them at the following falling edge, which is half a period later, within the same cycle and before the next pattern. The expected values come from a model that replays the register file and then the write-back, memory and execute stages, oldest first.

// File: rtl/cipher_operand_bypass.sv
module cipher_operand_bypass #(
  parameter int WORD_W    = 32,
  parameter int ADDR_W    = 4,
  parameter int KEY_WORDS = 4
) (
  input  logic [1:0]                  ex_kind,
  input  logic [ADDR_W-1:0]           ex_addr,
  input  logic [2*WORD_W-1:0]         ex_data,
  input  logic                        ex_last_step,
  input  logic [1:0]                  mem_kind,
  input  logic [ADDR_W-1:0]           mem_addr,
  input  logic [2*WORD_W-1:0]         mem_data,
  input  logic [1:0]                  wb_kind,
  input  logic [ADDR_W-1:0]           wb_addr,
  input  logic [2*WORD_W-1:0]         wb_data,
  input  logic [2*WORD_W-1:0]         rf_block,
  input  logic [KEY_WORDS*WORD_W-1:0] rf_key,
  output logic [2*WORD_W-1:0]         cur_block,
  output logic [KEY_WORDS*WORD_W-1:0] cur_key,
  output logic [2:0]                  int_bypass_kill
);

  localparam int NSTG  = 3;
  localparam int NREG  = 2 + KEY_WORDS;
  localparam int BLK_W = 2 * WORD_W;
  localparam logic [1:0] K_NONE   = 2'd0;
  localparam logic [1:0] K_XOR_II = 2'd1;
  localparam logic [1:0] K_XOR_IE = 2'd2;
  localparam logic [1:0] K_CIPHER = 2'd3;

  logic [1:0]        st_kind [NSTG];
  logic [ADDR_W-1:0] st_addr [NSTG];
  logic [BLK_W-1:0]  st_data [NSTG];
  logic [NSTG-1:0]   st_xor, st_ct;
  logic [WORD_W-1:0] fwd [NREG];

  assign st_kind[0] = ex_kind;  assign st_addr[0] = ex_addr;  assign st_data[0] = ex_data;
  assign st_kind[1] = mem_kind; assign st_addr[1] = mem_addr; assign st_data[1] = mem_data;
  assign st_kind[2] = wb_kind;  assign st_addr[2] = wb_addr;  assign st_data[2] = wb_data;

  genvar s, r;
  generate
    for (s = 0; s < NSTG; s++) begin : g_stage
      assign st_xor[s] = (st_kind[s] == K_XOR_II) || (st_kind[s] == K_XOR_IE);
      assign st_ct[s]  = (st_kind[s] == K_CIPHER) && ((s != 0) || ex_last_step);
      assign int_bypass_kill[s] = st_kind[s] != K_NONE;
    end

    for (r = 0; r < NREG; r++) begin : g_reg
      logic [NSTG-1:0]   hit;
      logic [WORD_W-1:0] val [NSTG];
      logic [WORD_W-1:0] stored;
      logic [WORD_W-1:0] pick;

      if (r < 2) begin : g_blk
        assign stored = rf_block[(1-r)*WORD_W +: WORD_W];
        for (s = 0; s < NSTG; s++) begin : g_src
          assign hit[s] = (st_xor[s] && st_addr[s] == ADDR_W'(r)) || st_ct[s];
          assign val[s] = st_ct[s] ? st_data[s][(1-r)*WORD_W +: WORD_W]
                                   : st_data[s][WORD_W-1:0];
        end
      end else begin : g_key
        assign stored = rf_key[(KEY_WORDS-1-(r-2))*WORD_W +: WORD_W];
        for (s = 0; s < NSTG; s++) begin : g_src
          assign hit[s] = st_xor[s] && st_addr[s] == ADDR_W'(r);
          assign val[s] = st_data[s][WORD_W-1:0];
        end
      end

      always_comb begin
        pick = stored;
        for (int k = NSTG - 1; k >= 0; k--)
          if (hit[k]) pick = val[k];
      end
      assign fwd[r] = pick;
    end

    for (r = 0; r < KEY_WORDS; r++) begin : g_keyout
      assign cur_key[(KEY_WORDS-1-r)*WORD_W +: WORD_W] = fwd[2+r];
    end
  endgenerate

  assign cur_block = {fwd[0], fwd[1]};

  always_comb begin
    if (int_bypass_kill == '0)
      assert_idle_passthru_R1: assert (cur_block == rf_block && cur_key == rf_key)
        else $error("idle stages altered operands");
    if (ex_kind == K_CIPHER && ex_last_step)
      assert_last_step_block_R6: assert (cur_block == ex_data && cur_key[WORD_W-1:0] == fwd[NREG-1])
        else $error("final cipher step not forwarded");
    if ((ex_kind == K_XOR_II || ex_kind == K_XOR_IE) && ex_addr == '0)
      assert_ex_youngest_R5: assert (cur_block[BLK_W-1 -: WORD_W] == ex_data[WORD_W-1:0])
        else $error("execute write to block high lost priority");
    if (cur_block != rf_block || cur_key != rf_key)
      assert_kill_on_forward_R9: assert (int_bypass_kill != '0)
        else $error("forwarded without integer bypass suppression");
  end

endmodule

// File: tb/cipher_operand_bypass_test.sv
module cipher_operand_bypass_test;

  typedef struct {
    logic [63:0]  blk;
    logic [127:0] key;
    logic [2:0]   kill;
    string        tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [1:0]   dk [3];
  logic [3:0]   da [3];
  logic [63:0]  dd [3];
  logic         dlast;
  logic [63:0]  drb;
  logic [127:0] drk;

  logic [1:0]   nk [3];
  logic [3:0]   na [3];
  logic [63:0]  nd [3];
  logic         nlast;
  logic [63:0]  nrb;
  logic [127:0] nrk;

  logic [63:0]  cur_block;
  logic [127:0] cur_key;
  logic [2:0]   int_bypass_kill;

  cipher_operand_bypass uut (
    .ex_kind(dk[0]), .ex_addr(da[0]), .ex_data(dd[0]), .ex_last_step(dlast),
    .mem_kind(dk[1]), .mem_addr(da[1]), .mem_data(dd[1]),
    .wb_kind(dk[2]), .wb_addr(da[2]), .wb_data(dd[2]),
    .rf_block(drb), .rf_key(drk),
    .cur_block(cur_block), .cur_key(cur_key), .int_bypass_kill(int_bypass_kill)
  );

  exp_t sb[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  function automatic exp_t model(string tag);
    exp_t e;
    logic [31:0] w [6];
    w[0] = nrb[63:32];
    w[1] = nrb[31:0];
    for (int k = 0; k < 4; k++) w[2+k] = nrk[127-32*k -: 32];
    for (int s = 2; s >= 0; s--) begin
      if (nk[s] == 2'd3 && (s != 0 || nlast)) begin
        w[0] = nd[s][63:32];
        w[1] = nd[s][31:0];
      end else if ((nk[s] == 2'd1 || nk[s] == 2'd2) && na[s] < 4'd6) begin
        w[na[s]] = nd[s][31:0];
      end
      e.kill[s] = nk[s] != 2'd0;
    end
    e.blk = {w[0], w[1]};
    e.key = {w[2], w[3], w[4], w[5]};
    e.tag = tag;
    return e;
  endfunction

  task automatic clear_stages();
    for (int s = 0; s < 3; s++) begin
      nk[s] = 2'd0;
      na[s] = 4'd0;
      nd[s] = 64'h0;
    end
    nlast = 1'b0;
  endtask

  task automatic set_stage(int s, logic [1:0] k, logic [3:0] a, logic [63:0] d);
    nk[s] = k;
    na[s] = a;
    nd[s] = d;
  endtask

  task automatic step(string tag);
    @(posedge clk);
    #1;
    for (int s = 0; s < 3; s++) begin
      dk[s] = nk[s];
      da[s] = na[s];
      dd[s] = nd[s];
    end
    dlast = nlast;
    drb = nrb;
    drk = nrk;
    sb.push_back(model(tag));
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() != 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (cur_block !== e.blk || cur_key !== e.key || int_bypass_kill !== e.kill) begin
          errors++;
          $display("FAIL %s: got blk=%h key=%h kill=%b expected blk=%h key=%h kill=%b",
                   e.tag, cur_block, cur_key, int_bypass_kill, e.blk, e.key, e.kill);
        end
      end
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 5000 && !done) begin
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
      end
    end
  end

  initial begin
    clear_stages();
    nrb = 64'h0123_4567_89AB_CDEF;
    nrk = 128'h1111_1111_2222_2222_3333_3333_4444_4444;
    for (int s = 0; s < 3; s++) begin
      dk[s] = 2'd0;
      da[s] = 4'd0;
      dd[s] = 64'h0;
    end
    dlast = 1'b0;
    drb = nrb;
    drk = nrk;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    step("R1 reset/idle passthrough");
    nrb = 64'hDEAD_BEEF_CAFE_F00D;
    step("R1 idle with new stored block");

    set_stage(0, 2'd0, 4'd0, 64'hAAAA_AAAA_5555_5555);
    set_stage(1, 2'd0, 4'd2, 64'h0000_0000_7777_7777);
    step("R3 other kinds ignored");

    clear_stages();
    set_stage(0, 2'd1, 4'd3, 64'hFFFF_FFFF_A1A1_A1A1);
    step("R2 EX kind1 key word addr3");
    clear_stages();
    set_stage(1, 2'd2, 4'd5, 64'h0000_0000_B2B2_B2B2);
    step("R2 MEM kind2 key word addr5");
    clear_stages();
    set_stage(2, 2'd1, 4'd0, 64'h0000_0000_C3C3_C3C3);
    step("R2 WB block high addr0");
    clear_stages();
    set_stage(0, 2'd2, 4'd1, 64'h0000_0000_D4D4_D4D4);
    set_stage(1, 2'd1, 4'd2, 64'h0000_0000_E5E5_E5E5);
    step("R2 two registers at once");

    clear_stages();
    set_stage(0, 2'd1, 4'd6, 64'h0000_0000_1234_5678);
    set_stage(1, 2'd2, 4'd9, 64'h0000_0000_8765_4321);
    set_stage(2, 2'd1, 4'd15, 64'h0000_0000_0BAD_0BAD);
    step("R4 constant addresses not forwarded");

    clear_stages();
    set_stage(0, 2'd1, 4'd2, 64'h0000_0000_0000_0E0E);
    set_stage(1, 2'd2, 4'd2, 64'h0000_0000_0000_0A0A);
    set_stage(2, 2'd1, 4'd2, 64'h0000_0000_0000_0B0B);
    step("R5 EX beats MEM and WB");
    clear_stages();
    set_stage(1, 2'd2, 4'd1, 64'h0000_0000_0000_1111);
    set_stage(2, 2'd1, 4'd1, 64'h0000_0000_0000_2222);
    step("R5 MEM beats WB");
    clear_stages();
    set_stage(0, 2'd1, 4'd4, 64'h0000_0000_0000_4444);
    set_stage(2, 2'd1, 4'd1, 64'h0000_0000_0000_3333);
    step("R5 per-register choice");

    clear_stages();
    set_stage(0, 2'd3, 4'd0, 64'h5A5A_5A5A_A5A5_A5A5);
    nlast = 1'b0;
    step("R6 cipher EX before last step");
    nlast = 1'b1;
    step("R6 cipher EX last step");

    clear_stages();
    set_stage(1, 2'd3, 4'd0, 64'h1357_9BDF_2468_ACE0);
    step("R7 cipher in MEM");
    clear_stages();
    set_stage(2, 2'd3, 4'd0, 64'hFEDC_BA98_7654_3210);
    step("R7 cipher in WB");

    clear_stages();
    set_stage(1, 2'd3, 4'd0, 64'h1111_2222_3333_4444);
    set_stage(0, 2'd1, 4'd0, 64'h0000_0000_9999_9999);
    step("R8 younger XOR beats cipher in MEM");
    clear_stages();
    set_stage(0, 2'd3, 4'd0, 64'h7777_8888_6666_5555);
    nlast = 1'b1;
    set_stage(1, 2'd2, 4'd1, 64'h0000_0000_ABAB_ABAB);
    set_stage(2, 2'd1, 4'd0, 64'h0000_0000_CDCD_CDCD);
    step("R8 last-step cipher beats older XOR");

    clear_stages();
    set_stage(1, 2'd1, 4'd8, 64'h0);
    step("R9 kill on MEM only");
    clear_stages();
    set_stage(0, 2'd3, 4'd0, 64'h0);
    set_stage(2, 2'd2, 4'd7, 64'h0);
    step("R9 kill on EX and WB");

    for (int i = 0; i < 40; i++) begin
      for (int s = 0; s < 3; s++)
        set_stage(s, 2'($urandom_range(0, 3)), 4'($urandom_range(0, 9)),
                  {$urandom(), $urandom()});
      nlast = 1'($urandom_range(0, 1));
      nrb = {$urandom(), $urandom()};
      nrk = {$urandom(), $urandom(), $urandom(), $urandom()};
      step("R10 R5 random mix");
    end

    clear_stages();
    step("R1 idle after traffic");
    @(posedge clk);
    @(posedge clk);
    done = 1;
    finish_run();
  end

endmodule